// File: doc/BRIEF.md
# Dual Multiplexer Logic Element

This block is a programmable logic element with eight logic inputs and two outputs. Four shared data lines feed two independent 4-to-1 multiplexers, and each multiplexer has its own pair of select lines. Each data line can be inverted by a configuration bit. The inversion is applied once, before the data fans out to both multiplexers. Each output can take the multiplexer result directly, or it can take it through a flip-flop.

The element maps two independent functions of three inputs, one per output. It can also map larger functions when both outputs draw on the same data signals. Each multiplexer always works as a single 4-to-1 unit and is never split into smaller multiplexers.

Configuration is six bits, loaded serially one bit per clock while the load enable is high, most significant bit first. After six load cycles the first bit shifted in sits in bit 5. Bits 5..2 invert data inputs 3..0, so bit 2+i inverts `data_i[i]`. Bit 1 selects the register for output 0 and bit 0 selects it for output 1; a value of 1 means registered and 0 means combinational. The logic inputs are plain level signals with no handshake, because a logic element has no transfer to throttle.

Top module: `dmle_core`

## Requirements
- R1: After reset, all configuration bits are 0, so each output equals `data_i[sel]` combinationally with no inversion.
- R2: Output 0 equals the conditioned data bit chosen by `sel_i[1:0]`; when its register bit is 0, this holds in the same cycle.
- R3: Output 1 selects from the same four conditioned data bits using `sel_i[3:2]`, independently of output 0.
- R4: When configuration bit 2+i is 1, data input i is inverted for both multiplexers.
- R5: On each rising edge with `cfg_en_i` high, the configuration shifts left by one and `cfg_bit_i` enters bit 0. After six loads, the first bit sent occupies bit 5.
- R6: While `cfg_en_i` is low, `cfg_bit_i` is ignored and the configuration holds.
- R7: When the register bit of an output is 1, that output shows the multiplexer value captured at the previous rising edge.
- R8: When the register bit of an output is 0, the flip-flop of that output holds its content. Re-selecting the register first shows that held value until the next rising edge.
- R9: A synchronous active-high `rst_i` clears the configuration and both output registers on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_en_i | input | 1 | Configuration load enable |
| cfg_bit_i | input | 1 | Serial configuration bit, MSB first |
| data_i | input | 4 | Shared data inputs |
| sel_i | input | 4 | Selects: [1:0] for output 0, [3:2] for output 1 |
| y_o | output | 2 | Element outputs |

## Verification
The bench goes after the bit ordering of the serial load. A reversed chain would invert the wrong data line, or register the wrong output.

It applies inversion while the two selects point at the same and at different data lines. An inversion placed after one multiplexer instead of on the shared data would then show on only one output.

It switches an output from registered to combinational and back. This catches a flip-flop that keeps loading while bypassed, because the stale value would differ from the held one.

It toggles the serial bit while the load enable is low. A chain that shifts regardless of the enable would corrupt the setup.

// File: rtl/dmle_pkg.sv
package dmle_pkg;
  typedef enum logic {
    PATH_COMB = 1'b0,
    PATH_REG  = 1'b1
  } path_e;

  // configuration width for a given data and output count
  function automatic int cfg_width(input int n_data, input int n_out);
    return n_data + n_out;
  endfunction
endpackage

// File: rtl/dmle_cfg_chain.sv
module dmle_cfg_chain #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chain_q <= '0;
    end else if (shift_en_i) begin
      chain_q <= {chain_q[W-2:0], bit_i};
    end
  end

  assign cfg_o = chain_q;
endmodule

// File: rtl/dmle_data_inv.sv
module dmle_data_inv #(
  parameter int N = 4
) (
  input  logic [N-1:0] data_i,
  input  logic [N-1:0] inv_i,
  output logic [N-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign data_o[g] = inv_i[g] ? ~data_i[g] : data_i[g];
  end
endmodule

// File: rtl/dmle_mux.sv
module dmle_mux #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic [N-1:0]  data_i,
  input  logic [SW-1:0] sel_i,
  output logic          y_o
);
  always_comb begin
    y_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SW'(k)) y_o = data_i[k];
    end
  end
endmodule

// File: rtl/dmle_out_stage.sv
module dmle_out_stage
  import dmle_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_i,
  input  path_e path_i,
  input  logic  d_i,
  output logic  q_o,
  output logic  y_o
);
  logic hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q <= 1'b0;
    end else if (path_i == PATH_REG) begin
      hold_q <= d_i;
    end
  end

  assign q_o = hold_q;
  assign y_o = (path_i == PATH_REG) ? hold_q : d_i;
endmodule

// File: rtl/dmle_core.sv
module dmle_core
  import dmle_pkg::*;
#(
  parameter int DATA_N = 4,
  parameter int OUT_N  = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic                                cfg_en_i,
  input  logic                                cfg_bit_i,
  input  logic [DATA_N-1:0]                   data_i,
  input  logic [OUT_N*$clog2(DATA_N)-1:0]     sel_i,
  output logic [OUT_N-1:0]                    y_o
);
  localparam int SW    = $clog2(DATA_N);
  localparam int CFG_W = cfg_width(DATA_N, OUT_N);

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_N-1:0] data_c;
  logic [OUT_N-1:0]  mux_y;
  logic [OUT_N-1:0]  reg_q;

  dmle_cfg_chain #(.W(CFG_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .shift_en_i (cfg_en_i),
    .bit_i      (cfg_bit_i),
    .cfg_o      (cfg_q)
  );

  dmle_data_inv #(.N(DATA_N)) u_inv (
    .data_i (data_i),
    .inv_i  (cfg_q[OUT_N +: DATA_N]),
    .data_o (data_c)
  );

  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    path_e path;
    assign path = path_e'(cfg_q[OUT_N-1-g]);

    dmle_mux #(.N(DATA_N), .SW(SW)) u_mux (
      .data_i (data_c),
      .sel_i  (sel_i[g*SW +: SW]),
      .y_o    (mux_y[g])
    );

    dmle_out_stage u_stage (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .path_i (path),
      .d_i    (mux_y[g]),
      .q_o    (reg_q[g]),
      .y_o    (y_o[g])
    );
  end
endmodule

// File: rtl/dmle_core_chk.sv
module dmle_core_chk #(
  parameter int DATA_N = 4,
  parameter int OUT_N  = 2
) (
  input logic                            clk_i,
  input logic                            rst_i,
  input logic                            cfg_en_i,
  input logic                            cfg_bit_i,
  input logic [DATA_N-1:0]               data_i,
  input logic [OUT_N*$clog2(DATA_N)-1:0] sel_i,
  input logic [OUT_N-1:0]                y_o,
  input logic [DATA_N+OUT_N-1:0]         cfg_q,
  input logic [OUT_N-1:0]                mux_y,
  input logic [OUT_N-1:0]                reg_q
);
  localparam int SW    = $clog2(DATA_N);
  localparam int CFG_W = DATA_N + OUT_N;

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    rst_i |=> (cfg_q == '0 && reg_q == '0)); // R9

  AST_CFG_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
    cfg_en_i |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_bit_i)}); // R5

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_en_i |=> $stable(cfg_q)); // R6

  for (genvar g = 0; g < OUT_N; g++) begin : g_chk
    logic [SW-1:0] s;
    logic          expect_bit;
    assign s          = sel_i[g*SW +: SW];
    assign expect_bit = data_i[s] ^ cfg_q[OUT_N + int'(s)];

    AST_COMB_PATH: assert property (@(posedge clk_i) disable iff (rst_i)
      !cfg_q[OUT_N-1-g] |-> y_o[g] == expect_bit); // R2

    AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
      cfg_q[OUT_N-1-g] |=> reg_q[g] == $past(mux_y[g])); // R7

    AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !cfg_q[OUT_N-1-g] |=> $stable(reg_q[g])); // R8
  end
endmodule

bind dmle_core dmle_core_chk #(.DATA_N(DATA_N), .OUT_N(OUT_N)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cfg_en_i  (cfg_en_i),
  .cfg_bit_i (cfg_bit_i),
  .data_i    (data_i),
  .sel_i     (sel_i),
  .y_o       (y_o),
  .cfg_q     (cfg_q),
  .mux_y     (mux_y),
  .reg_q     (reg_q)
);

// File: tb/dmle_core_test.sv
module dmle_core_test;
  logic       clk = 1'b0;
  logic       rst, cfg_en, cfg_bit;
  logic [3:0] din;
  logic [3:0] sel;
  logic [1:0] y;

  int total = 0;
  int bad   = 0;
  logic       finished = 1'b0;
  logic [5:0] mcfg;
  logic [1:0] mq;

  always #2 clk = ~clk;

  dmle_core uut (
    .clk_i     (clk),
    .rst_i     (rst),
    .cfg_en_i  (cfg_en),
    .cfg_bit_i (cfg_bit),
    .data_i    (din),
    .sel_i     (sel),
    .y_o       (y)
  );

  // multiplexer results from the requirement definitions
  function automatic logic [1:0] mux_exp(input logic [5:0] c, input logic [3:0] d,
                                         input logic [3:0] s);
    logic [3:0] cd;
    cd = d ^ c[5:2];
    return {cd[s[3:2]], cd[s[1:0]]};
  endfunction

  function automatic logic [1:0] out_exp(input logic [5:0] c, input logic [1:0] q,
                                         input logic [3:0] d, input logic [3:0] s);
    logic [1:0] m;
    m = mux_exp(c, d, s);
    return {c[0] ? q[1] : m[1], c[1] ? q[0] : m[0]};
  endfunction

  task automatic cycle(input string tag, input logic r, input logic e, input logic b,
                       input logic [3:0] d, input logic [3:0] s);
    logic [1:0] exp_y;
    logic [1:0] m;
    @(negedge clk);
    rst = r; cfg_en = e; cfg_bit = b; din = d; sel = s;
    #1;
    exp_y = out_exp(mcfg, mq, d, s);
    total++;
    if (y !== exp_y) begin
      bad++;
      $display("FAIL %s: y=%b expected %b (cfg=%b)", tag, y, exp_y, mcfg);
    end
    @(posedge clk);
    m = mux_exp(mcfg, d, s);
    if (r) begin
      mcfg = '0; mq = '0;
    end else begin
      if (mcfg[1]) mq[0] = m[0];
      if (mcfg[0]) mq[1] = m[1];
      if (e) mcfg = {mcfg[4:0], b};
    end
  endtask

  task automatic load(input string tag, input logic [5:0] c);
    for (int i = 5; i >= 0; i--) cycle(tag, 1'b0, 1'b1, c[i], 4'($urandom), 4'($urandom));
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 1'b0, 1'($urandom), 4'($urandom), 4'($urandom));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: y=%b expected completion", y);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mcfg = 'x; mq = 'x;
    rst = 1'b1; cfg_en = 1'b0; cfg_bit = 1'b0; din = '0; sel = '0;
    @(posedge clk);
    mcfg = '0; mq = '0;
    cycle("R9", 1'b1, 1'b1, 1'b1, 4'hF, 4'h0);
    run("R1", 8);
    // R3: selects pointing at different and equal lines
    for (int s = 0; s < 16; s++) cycle("R3", 1'b0, 1'b0, 1'b0, 4'b0110, 4'(s));
    load("R5", 6'b1010_00);
    for (int s = 0; s < 16; s++) cycle("R4", 1'b0, 1'b0, 1'b0, 4'b0000, 4'(s));
    for (int s = 0; s < 16; s++) cycle("R4", 1'b0, 1'b0, 1'b0, 4'b1111, 4'(s));
    // R6: serial bit toggles with enable low
    for (int i = 0; i < 8; i++) cycle("R6", 1'b0, 1'b0, 1'(i), 4'b0000, 4'b1101);
    load("R5", 6'b0000_11);
    run("R7", 20);
    load("R8", 6'b0000_01);
    run("R8", 10);
    load("R8", 6'b0000_11);
    run("R8", 4);
    // R2: random mix with occasional loads and resets
    for (int i = 0; i < 3000; i++) begin
      cycle("R2", ($urandom % 64) == 0, ($urandom % 4) == 0, 1'($urandom),
            4'($urandom), 4'($urandom));
    end
    cycle("R9", 1'b1, 1'b0, 1'b0, 4'h5, 4'h6);
    run("R1", 4);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule